// File: doc/BRIEF.md
# Vector-to-Port Scatter Mapper

This block connects an eight-lane vector source to four input FIFOs of a compute fabric, and four output FIFOs of that fabric back to an eight-lane store vector. A programmable map holds one entry per lane. Each entry either names a destination port and an order index, or marks the lane as unused. When a whole vector is admitted, each lane that is in use is pushed into its named port. Lanes that share a port enter its FIFO one per cycle, in the order the index gives. This lets a single wide load feed several unrolled copies of a computation, or spread a strided access pattern across ports.

The gather direction mirrors this with its own map. After a start pulse it pops the fabric's output ports, steering each popped element into the lane that the map assigns to that position of the port's stream. Once every mapped lane has been filled it presents the assembled vector with per-lane byte-enables. Unused lanes read as zero with their enable cleared.

The scatter side is a two-state machine. SC_IDLE moves to SC_PUSH when a vector with at least one lane in use is admitted. SC_PUSH returns to SC_IDLE on the cycle its last element is pushed. The gather side has three states. GA_IDLE moves to GA_FILL on start, or straight to GA_DONE when no lane is mapped. GA_FILL moves to GA_DONE when its last lane is filled. GA_DONE moves to GA_IDLE when the store side accepts the vector.

Top module: `vport_mapper`

## Requirements
- R1: After reset no push or pop is asserted, `st_valid` is 0, and both maps hold every lane as unused. A vector offered in this state is admitted even with all free counts at 0 and produces no push.
- R2: Map entry i sits at `cfg_map[7i+6:7i]`. Bit 6 is the use flag, bits 5:3 the port code and bits 2:0 the order index. A write with `cfg_sel`=0 loads the scatter map; `cfg_sel`=1 loads the gather map. Each lane in use pushes its own data word onto the port its entry names.
- R3: Each port receives its elements in ascending order index, with ties taken lowest lane first. One element is pushed per port per cycle, with no gaps. The first push comes in the cycle right after the vector is admitted.
- R4: A lane whose use flag is 0, or whose port code is 4 to 7, is never pushed. It does not count toward admission.
- R5: A vector is admitted (`vec_ready`=1 in SC_IDLE) only when, for every port, the free count is at least the number of lanes mapped to that port. A shortfall of one on any single port holds off the whole vector.
- R6: `vec_ready` stays 0 through every push cycle. It returns to 1 in the cycle after the last push.
- R7: A map write is ignored while the machine it targets is busy (scatter in SC_PUSH; gather in GA_FILL or GA_DONE). The old map stays in effect.
- R8: In GA_FILL a port is popped only while its `out_valid` is high, and no more times than the number of lanes mapped to it. The k-th element popped from a port fills the k-th lane of that port under the R3 ordering. `st_valid` rises once all mapped lanes are filled.
- R9: In the presented store vector, mapped lanes have their `st_be` bit set. Unused lanes have their `st_be` bit cleared and their data set to zero.
- R10: `st_valid`, `st_data` and `st_be` hold steady while `st_ready` is 0. The cycle after `st_ready` is seen, `st_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Map write strobe |
| cfg_sel | input | 1 | 0 selects scatter map, 1 gather map |
| cfg_map | input | 56 | Eight 7-bit map entries |
| vec_valid | input | 1 | Source vector offered |
| vec_ready | output | 1 | Vector admitted this cycle when valid |
| vec_data | input | 64 | Eight 8-bit source lanes |
| port_free | input | 16 | Free count of each input FIFO, 4 bits each |
| push | output | 4 | Push strobe per input FIFO |
| push_data | output | 32 | Data word per input FIFO |
| gat_start | input | 1 | Begin assembling one store vector |
| out_valid | input | 4 | Output FIFO not empty |
| out_data | input | 32 | Head word of each output FIFO |
| out_pop | output | 4 | Pop strobe per output FIFO |
| st_valid | output | 1 | Store vector complete |
| st_ready | input | 1 | Store vector taken |
| st_data | output | 64 | Assembled store vector |
| st_be | output | 8 | Byte-enable per lane |

## Verification
The bench builds the block with its default sizes: eight 8-bit lanes, four ports, 3-bit port codes and 4-bit free counts. With a 3-bit port code, codes 4 to 7 can be reached, so out-of-range discards are exercised alongside the cleared use flag. The 4-bit free counts cover every exact-fit and short-by-one admission case up to eight lanes on one port. Sweeps over arithmetically generated maps produce ties in the order index, reversed orders, and fully discarded vectors. The gather sweeps stall the output ports in several patterns.

// File: rtl/vsm_pkg.sv
`timescale 1ns/1ps
package vsm_pkg;
    localparam int SEL_W = 3;
    localparam int ORD_W = 3;
    localparam int ENT_W = 1 + SEL_W + ORD_W;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] port;
        logic [ORD_W-1:0] ord;
    } map_ent_t;

    typedef enum logic {SC_IDLE, SC_PUSH} sc_state_t;
    typedef enum logic [1:0] {GA_IDLE, GA_FILL, GA_DONE} ga_state_t;

    function automatic logic lane_live(map_ent_t e, int nport);
        return e.en && (int'(e.port) < nport);
    endfunction
endpackage

// File: rtl/vsm_map_regs.sv
`timescale 1ns/1ps
module vsm_map_regs
    import vsm_pkg::*;
#(
    parameter int NLANE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic                    cfg_sel,
    input  logic [NLANE*ENT_W-1:0]  cfg_map,
    input  logic                    sc_busy,
    input  logic                    ga_busy,
    output map_ent_t [NLANE-1:0]    smap,
    output map_ent_t [NLANE-1:0]    gmap
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smap <= '0;
            gmap <= '0;
        end else if (cfg_we) begin
            if (!cfg_sel && !sc_busy) smap <= cfg_map;
            if (cfg_sel && !ga_busy)  gmap <= cfg_map;
        end
    end

    // R7: maps frozen while their machine is busy
    p_smap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sc_busy |=> $stable(smap));
    p_gmap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ga_busy |=> $stable(gmap));
endmodule

// File: rtl/vsm_pick.sv
`timescale 1ns/1ps
module vsm_pick
    import vsm_pkg::*;
#(
    parameter int NLANE = 8,
    parameter int NPORT = 4
) (
    input  logic [NLANE-1:0]                    pend,
    input  map_ent_t [NLANE-1:0]                map,
    output logic [NPORT-1:0]                    hit,
    output logic [NPORT-1:0][$clog2(NLANE)-1:0] sel
);
    localparam int LW = $clog2(NLANE);
    localparam int KW = ORD_W + LW;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic          found;
        logic [LW-1:0] lane;
        logic [KW-1:0] best;
        always_comb begin
            found = 1'b0;
            lane  = '0;
            best  = '1;
            for (int i = 0; i < NLANE; i++) begin
                if (pend[i] && lane_live(map[i], NPORT) && int'(map[i].port) == p) begin
                    if (!found || {map[i].ord, LW'(i)} < best) begin
                        best  = {map[i].ord, LW'(i)};
                        lane  = LW'(i);
                        found = 1'b1;
                    end
                end
            end
        end
        assign hit[p] = found;
        assign sel[p] = lane;
    end
endmodule

// File: rtl/vsm_scatter.sv
`timescale 1ns/1ps
module vsm_scatter
    import vsm_pkg::*;
#(
    parameter int NLANE  = 8,
    parameter int NPORT  = 4,
    parameter int DW     = 8,
    parameter int FREE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  map_ent_t [NLANE-1:0]      smap,
    input  logic                      vec_valid,
    input  logic [NLANE*DW-1:0]       vec_data,
    output logic                      vec_ready,
    input  logic [NPORT*FREE_W-1:0]   port_free,
    output logic [NPORT-1:0]          push,
    output logic [NPORT*DW-1:0]       push_data,
    output logic                      busy
);
    localparam int LW = $clog2(NLANE);
    localparam int CW = $clog2(NLANE + 1);

    sc_state_t                  state, state_nx;
    logic [NLANE-1:0]           pend, pend_nx, live, clr;
    logic [NLANE-1:0][DW-1:0]   dbuf;
    logic [NPORT-1:0]           fits, hit;
    logic [NPORT-1:0][LW-1:0]   sel;
    logic                       take;

    for (genvar i = 0; i < NLANE; i++) begin : g_live
        assign live[i] = lane_live(smap[i], NPORT);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_need
        logic [CW-1:0] need;
        always_comb begin
            need = '0;
            for (int i = 0; i < NLANE; i++)
                if (live[i] && int'(smap[i].port) == p) need = need + CW'(1);
        end
        assign fits[p] = int'(need) <= int'(port_free[p*FREE_W +: FREE_W]);
        assign push_data[p*DW +: DW] = dbuf[sel[p]];
    end

    vsm_pick #(.NLANE(NLANE), .NPORT(NPORT)) u_pick (
        .pend (pend),
        .map  (smap),
        .hit  (hit),
        .sel  (sel)
    );

    // outputs
    always_comb begin
        vec_ready = (state == SC_IDLE) && (&fits);
        push      = (state == SC_PUSH) ? hit : '0;
        busy      = (state != SC_IDLE);
    end

    assign take = vec_valid && vec_ready;

    always_comb begin
        clr = '0;
        for (int p = 0; p < NPORT; p++)
            if (push[p]) clr[sel[p]] = 1'b1;
    end

    always_comb begin
        state_nx = state;
        pend_nx  = pend;
        unique case (state)
            SC_IDLE: begin
                if (take && live != '0) begin
                    state_nx = SC_PUSH;
                    pend_nx  = live;
                end
            end
            SC_PUSH: begin
                pend_nx = pend & ~clr;
                if (pend_nx == '0) state_nx = SC_IDLE;
            end
            default: state_nx = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SC_IDLE;
            pend  <= '0;
        end else begin
            state <= state_nx;
            pend  <= pend_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (take) dbuf <= vec_data;
    end

    // R3: every push cycle moves at least one element, pending set only shrinks
    p_push_each_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_PUSH) |-> (push != '0));
    p_pend_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_PUSH) |=> ((pend & ~$past(pend)) == '0));
    // R6: nothing is pushed and nothing partial issued outside a push phase
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_IDLE) |-> (push == '0));
endmodule

// File: rtl/vsm_gather.sv
`timescale 1ns/1ps
module vsm_gather
    import vsm_pkg::*;
#(
    parameter int NLANE = 8,
    parameter int NPORT = 4,
    parameter int DW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  map_ent_t [NLANE-1:0]  gmap,
    input  logic                  start,
    input  logic [NPORT-1:0]      out_valid,
    input  logic [NPORT*DW-1:0]   out_data,
    output logic [NPORT-1:0]      out_pop,
    output logic                  st_valid,
    input  logic                  st_ready,
    output logic [NLANE*DW-1:0]   st_data,
    output logic [NLANE-1:0]      st_be,
    output logic                  busy
);
    localparam int LW = $clog2(NLANE);

    ga_state_t                  state, state_nx;
    logic [NLANE-1:0]           pend, pend_nx, live, clr, dirty;
    logic [NLANE-1:0][DW-1:0]   dreg;
    logic [NPORT-1:0]           hit;
    logic [NPORT-1:0][LW-1:0]   sel;

    for (genvar i = 0; i < NLANE; i++) begin : g_live
        assign live[i]  = lane_live(gmap[i], NPORT);
        assign dirty[i] = !st_be[i] && (dreg[i] != '0);
    end

    vsm_pick #(.NLANE(NLANE), .NPORT(NPORT)) u_pick (
        .pend (pend),
        .map  (gmap),
        .hit  (hit),
        .sel  (sel)
    );

    // outputs
    always_comb begin
        out_pop  = (state == GA_FILL) ? (hit & out_valid) : '0;
        st_valid = (state == GA_DONE);
        st_be    = st_valid ? live : '0;
        busy     = (state != GA_IDLE);
    end

    assign st_data = dreg;

    always_comb begin
        clr = '0;
        for (int p = 0; p < NPORT; p++)
            if (out_pop[p]) clr[sel[p]] = 1'b1;
    end

    always_comb begin
        state_nx = state;
        pend_nx  = pend;
        unique case (state)
            GA_IDLE: begin
                if (start) begin
                    pend_nx  = live;
                    state_nx = (live == '0) ? GA_DONE : GA_FILL;
                end
            end
            GA_FILL: begin
                pend_nx = pend & ~clr;
                if (pend_nx == '0) state_nx = GA_DONE;
            end
            GA_DONE: begin
                if (st_ready) state_nx = GA_IDLE;
            end
            default: state_nx = GA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GA_IDLE;
            pend  <= '0;
        end else begin
            state <= state_nx;
            pend  <= pend_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreg <= '0;
        end else if (state == GA_IDLE && start) begin
            dreg <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++)
                if (out_pop[p]) dreg[sel[p]] <= out_data[p*DW +: DW];
        end
    end

    // R8: a complete vector has no lane still pending
    p_done_filled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GA_DONE) |-> (pend == '0));
    // R9: lanes without byte-enable carry zero
    p_zero_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (dirty == '0));
    // R10: presented vector holds until taken
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_be)));
endmodule

// File: rtl/vport_mapper.sv
`timescale 1ns/1ps
module vport_mapper
    import vsm_pkg::*;
#(
    parameter int NLANE  = 8,
    parameter int NPORT  = 4,
    parameter int DW     = 8,
    parameter int FREE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_sel,
    input  logic [NLANE*ENT_W-1:0]   cfg_map,
    input  logic                     vec_valid,
    output logic                     vec_ready,
    input  logic [NLANE*DW-1:0]      vec_data,
    input  logic [NPORT*FREE_W-1:0]  port_free,
    output logic [NPORT-1:0]         push,
    output logic [NPORT*DW-1:0]      push_data,
    input  logic                     gat_start,
    input  logic [NPORT-1:0]         out_valid,
    input  logic [NPORT*DW-1:0]      out_data,
    output logic [NPORT-1:0]         out_pop,
    output logic                     st_valid,
    input  logic                     st_ready,
    output logic [NLANE*DW-1:0]      st_data,
    output logic [NLANE-1:0]         st_be
);
    map_ent_t [NLANE-1:0] smap, gmap;
    logic                  sc_busy, ga_busy;

    vsm_map_regs #(.NLANE(NLANE)) u_maps (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .cfg_map (cfg_map),
        .sc_busy (sc_busy),
        .ga_busy (ga_busy),
        .smap    (smap),
        .gmap    (gmap)
    );

    vsm_scatter #(.NLANE(NLANE), .NPORT(NPORT), .DW(DW), .FREE_W(FREE_W)) u_scatter (
        .clk       (clk),
        .rst_n     (rst_n),
        .smap      (smap),
        .vec_valid (vec_valid),
        .vec_data  (vec_data),
        .vec_ready (vec_ready),
        .port_free (port_free),
        .push      (push),
        .push_data (push_data),
        .busy      (sc_busy)
    );

    vsm_gather #(.NLANE(NLANE), .NPORT(NPORT), .DW(DW)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .gmap      (gmap),
        .start     (gat_start),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_pop   (out_pop),
        .st_valid  (st_valid),
        .st_ready  (st_ready),
        .st_data   (st_data),
        .st_be     (st_be),
        .busy      (ga_busy)
    );
endmodule

// File: tb/vport_mapper_test.sv
`timescale 1ns/1ps
module vport_mapper_test;
    localparam int NL = 8;
    localparam int NP = 4;
    localparam int DW = 8;
    localparam int FW = 4;
    localparam int EW = 7;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [NL*EW-1:0]  cfg_map = '0;
    logic              vec_valid = 1'b0;
    logic              vec_ready;
    logic [NL*DW-1:0]  vec_data = '0;
    logic [NP*FW-1:0]  port_free = '0;
    logic [NP-1:0]     push;
    logic [NP*DW-1:0]  push_data;
    logic              gat_start = 1'b0;
    logic [NP-1:0]     out_valid = '0;
    logic [NP*DW-1:0]  out_data = '0;
    logic [NP-1:0]     out_pop;
    logic              st_valid;
    logic              st_ready = 1'b0;
    logic [NL*DW-1:0]  st_data;
    logic [NL-1:0]     st_be;

    vport_mapper uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_map(cfg_map),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
        .port_free(port_free), .push(push), .push_data(push_data),
        .gat_start(gat_start), .out_valid(out_valid), .out_data(out_data), .out_pop(out_pop),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_be(st_be)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errs = 0, checks = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bench-side map and expected streams
    logic [6:0] bmap [NL];
    int ex_lane [NP][NL];
    int ex_n [NP];

    function automatic logic [6:0] ent(input int t, input int i);
        logic en;
        int pt, od;
        en = ((t*7 + i*3) % 5) != 0;
        pt = (t + i*5 + t/3) % 6;
        od = ((t + i) * (t % 3 + 1)) % 8;
        return {en, 3'(pt), 3'(od)};
    endfunction

    task automatic build_exp();
        for (int p = 0; p < NP; p++) ex_n[p] = 0;
        for (int key = 0; key < 64; key++) begin
            int ln, od, pt;
            ln = key % 8;
            od = key / 8;
            pt = int'(bmap[ln][5:3]);
            if (bmap[ln][6] && pt < NP && int'(bmap[ln][2:0]) == od) begin
                ex_lane[pt][ex_n[pt]] = ln;
                ex_n[pt]++;
            end
        end
    endtask

    task automatic write_map(input bit gsel);
        @(negedge clk);
        for (int i = 0; i < NL; i++) cfg_map[i*EW +: EW] = bmap[i];
        cfg_sel = gsel;
        cfg_we  = 1'b1;
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    task automatic set_free(input int p, input int v);
        port_free[p*FW +: FW] = FW'(v);
    endtask

    // scatter monitor
    int rx_data [NP][$];
    int rx_cyc  [NP][$];
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (push[p]) begin
                rx_data[p].push_back(int'(push_data[p*DW +: DW]));
                rx_cyc[p].push_back(cyc);
            end
        end
    end

    task automatic run_scatter(input int seed, input bit junk);
        int maxn, acc, bp, tot;
        logic [7:0] d [NL];
        build_exp();
        maxn = 0;
        for (int p = 0; p < NP; p++) if (ex_n[p] > maxn) maxn = ex_n[p];
        for (int i = 0; i < NL; i++) begin
            d[i] = 8'(seed*8 + i);
            vec_data[i*DW +: DW] = d[i];
        end
        for (int p = 0; p < NP; p++) begin
            rx_data[p].delete();
            rx_cyc[p].delete();
        end
        bp = -1;
        for (int q = 0; q < NP; q++) begin
            int p;
            p = (seed + q) % NP;
            if (bp < 0 && ex_n[p] > 0) bp = p;
        end
        for (int p = 0; p < NP; p++) set_free(p, ex_n[p]);
        if (bp >= 0) set_free(bp, ex_n[bp] - 1);
        vec_valid = 1'b1;
        #1;
        if (bp >= 0) begin
            chk(vec_ready == 1'b0, "R5", "ready with one port short", int'(vec_ready), 0);
            @(negedge clk);
            #1;
            tot = 0;
            for (int p = 0; p < NP; p++) tot += rx_data[p].size();
            chk(vec_ready == 1'b0 && tot == 0, "R5", "held vector stays whole", tot, 0);
            set_free(bp, ex_n[bp]);
            #1;
        end
        chk(vec_ready == 1'b1, "R5", "ready on exact fit", int'(vec_ready), 1);
        @(posedge clk);
        @(negedge clk);
        acc = cyc;
        vec_valid = 1'b0;
        for (int p = 0; p < NP; p++) set_free(p, 15);
        if (junk) begin
            for (int i = 0; i < NL; i++) cfg_map[i*EW +: EW] = 7'b1_000_000;
            cfg_sel = 1'b0;
            cfg_we  = 1'b1;
        end
        for (int k = 0; k < maxn; k++) begin
            #1;
            chk(vec_ready == 1'b0, "R6", "ready during push", int'(vec_ready), 0);
            @(negedge clk);
            cfg_we = 1'b0;
        end
        cfg_we = 1'b0;
        #1;
        chk(vec_ready == 1'b1, "R6", "ready after last push", int'(vec_ready), 1);
        repeat (2) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(rx_data[p].size() == ex_n[p], "R4", "push count on port", rx_data[p].size(), ex_n[p]);
            for (int k = 0; k < ex_n[p] && k < rx_data[p].size(); k++) begin
                chk(rx_data[p][k] == int'(d[ex_lane[p][k]]), "R2", "pushed word",
                    rx_data[p][k], int'(d[ex_lane[p][k]]));
                chk(rx_cyc[p][k] == acc + k, "R3", "push cycle", rx_cyc[p][k], acc + k);
            end
        end
    endtask

    // gather side output FIFO model
    logic [7:0] gq [NP][$];
    logic [NP-1:0] popped_last = '0;
    int stall_mod = 0;
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++)
            if (popped_last[p] && gq[p].size() > 0) void'(gq[p].pop_front());
        for (int p = 0; p < NP; p++) begin
            out_valid[p] = (gq[p].size() > 0) && (stall_mod == 0 || ((cyc + p) % stall_mod) != 0);
            out_data[p*DW +: DW] = (gq[p].size() > 0) ? gq[p][0] : 8'h00;
        end
        #1;
        popped_last = out_pop & out_valid;
    end

    task automatic run_gather(input int seed, input bit junk, input int sm);
        logic [7:0] exd [NL];
        logic [NL-1:0] exbe;
        logic [NL*DW-1:0] snap;
        int w;
        build_exp();
        stall_mod = sm;
        exbe = '0;
        for (int i = 0; i < NL; i++) exd[i] = 8'h00;
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < ex_n[p]; k++) begin
                logic [7:0] v;
                v = 8'(((seed*5 + p*8 + k) % 254) + 1);
                gq[p].push_back(v);
                exd[ex_lane[p][k]] = v;
                exbe[ex_lane[p][k]] = 1'b1;
            end
            gq[p].push_back(8'hFF);
        end
        @(negedge clk);
        gat_start = 1'b1;
        @(negedge clk);
        gat_start = 1'b0;
        if (junk) begin
            for (int i = 0; i < NL; i++) cfg_map[i*EW +: EW] = 7'b1_000_000;
            cfg_sel = 1'b1;
            cfg_we  = 1'b1;
            @(negedge clk);
            cfg_we  = 1'b0;
        end
        #2;
        w = 0;
        while (!st_valid && w < 300) begin
            @(negedge clk);
            #2;
            w++;
        end
        chk(st_valid == 1'b1, "R8", "store vector completes", int'(st_valid), 1);
        for (int i = 0; i < NL; i++) begin
            chk(st_data[i*DW +: DW] == exd[i], exbe[i] ? "R8" : "R9", "lane data",
                int'(st_data[i*DW +: DW]), int'(exd[i]));
        end
        chk(st_be == exbe, junk ? "R7" : "R9", "byte enables", int'(st_be), int'(exbe));
        for (int p = 0; p < NP; p++)
            chk(gq[p].size() == 1, "R8", "pops beyond mapped count", gq[p].size(), 1);
        snap = st_data;
        @(negedge clk);
        #2;
        chk(st_valid == 1'b1 && st_data == snap, "R10", "hold while not ready", int'(st_valid), 1);
        st_ready = 1'b1;
        @(negedge clk);
        st_ready = 1'b0;
        #2;
        chk(st_valid == 1'b0, "R10", "valid drops after take", int'(st_valid), 0);
        for (int p = 0; p < NP; p++) gq[p].delete();
        stall_mod = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(push == '0, "R1", "push after reset", int'(push), 0);
        chk(out_pop == '0, "R1", "pop after reset", int'(out_pop), 0);
        chk(st_valid == 1'b0, "R1", "st_valid after reset", int'(st_valid), 0);
        chk(vec_ready == 1'b1, "R1", "empty map admits with zero free", int'(vec_ready), 1);
        vec_data = 64'h0123_4567_89AB_CDEF;
        vec_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        vec_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_data[0].size() + rx_data[1].size() + rx_data[2].size() + rx_data[3].size() == 0,
            "R1", "no push from reset map", rx_data[0].size(), 0);

        // reversed order, all lanes to port 2
        for (int i = 0; i < NL; i++) bmap[i] = {1'b1, 3'd2, 3'(7 - i)};
        write_map(1'b0);
        run_scatter(200, 1'b0);
        // ties on order index, all lanes to port 1
        for (int i = 0; i < NL; i++) bmap[i] = {1'b1, 3'd1, 3'd0};
        write_map(1'b0);
        run_scatter(201, 1'b0);
        // only discards: cleared flag or port codes 4..7
        for (int i = 0; i < NL; i++) bmap[i] = (i % 2 == 0) ? {1'b0, 3'(i % 4), 3'd0} : {1'b1, 3'(4 + i % 4), 3'd1};
        write_map(1'b0);
        run_scatter(202, 1'b0);
        // R7: write during push ignored
        for (int i = 0; i < NL; i++) bmap[i] = {1'b1, 3'(i % 4), 3'(i / 4)};
        write_map(1'b0);
        run_scatter(203, 1'b1);
        run_scatter(204, 1'b0);

        for (int t = 0; t < 64; t++) begin
            for (int i = 0; i < NL; i++) bmap[i] = ent(t, i);
            write_map(1'b0);
            run_scatter(t, 1'b0);
        end

        // gather: empty map, then sweeps with stalls
        for (int i = 0; i < NL; i++) bmap[i] = 7'b0;
        write_map(1'b1);
        run_gather(300, 1'b0, 0);
        for (int t = 0; t < 40; t++) begin
            int sms [4] = '{0, 2, 3, 5};
            for (int i = 0; i < NL; i++) bmap[i] = ent(t + 100, i);
            write_map(1'b1);
            run_gather(t, (t % 5) == 1, sms[t % 4]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule